// File: doc/BRIEF.md
# Next-PC and Interrupt-Enable Controller

This block sits at the branch stage of a 32-bit in-order core. Each cycle it takes the address of the instruction being retired and the decoded flow kind. From these it works out the address of the next instruction. The flow kinds are sequential fall-through, a two-register compare branch, an immediate jump or call, a register jump or call, a system call and a break. It also produces the return-link write for calls, and flags the two software-raised exceptions together with the address of the faulting instruction.

The block also holds the three-bit interrupt-enable state. On entry to an exception or a breakpoint, the exception logic pulses a request. The global enable is then parked in the matching saved bit and cleared. A register jump through the exception-return register or the breakpoint-return register puts the global enable back from the matching saved bit. Software can overwrite all three bits with a CSR write. The value written is visible on `ie_o` before the next instruction retires. Vector selection, masking and pending logic live elsewhere.

Top module: `brie_ctrl`

## Requirements
- R1: For flow kind 0 (sequential), `next_pc_o` is the aligned `pc_i` plus 4. Flow kinds are 0 seq, 1 compare branch, 2 immediate jump, 3 immediate call, 4 register jump, 5 register call, 6 system call, 7 break.
- R2: A compare branch is taken when `opa_i`/`opb_i` satisfy `cmp_op_i`. The codes are 0 equal, 1 not equal, 2 signed greater, 3 signed greater-or-equal, 4 unsigned greater, 5 unsigned greater-or-equal. Codes 6 and 7 are never taken.
- R3: A taken compare branch goes to the aligned PC plus `imm16_i` sign-extended and shifted left by 2. A branch that is not taken goes to the aligned PC plus 4.
- R4: Immediate jump and immediate call go to the aligned PC plus `imm26_i` sign-extended and shifted left by 2. Negative offsets move backward.
- R5: Immediate and register calls with `step_i` high assert `link_we_o`, with `link_idx_o` = 29 and `link_data_o` = aligned PC plus 4. No other kind asserts `link_we_o`.
- R6: Register jump and register call go to `opa_i` with its low two bits cleared.
- R7: When `step_i` is high, a system call raises `sys_exc_o` and a break raises `brk_exc_o`. Either one puts the aligned PC on `fault_pc_o` and on `next_pc_o`. The two flags are never high together.
- R8: `ie_o` bit 0 is the global enable, bit 1 is the exception-saved copy and bit 2 is the breakpoint-saved copy. All three reset to 0.
- R9: `exc_entry_i` copies bit 0 into bit 1 and clears bit 0. `brk_entry_i` copies bit 0 into bit 2 and clears bit 0. If both are high, only the breakpoint entry acts. Each takes effect on the next edge.
- R10: A register jump with `step_i` high and `opa_idx_i` = 30 sets bit 0 from bit 1. With `opa_idx_i` = 31 it sets bit 0 from bit 2. The saved bits are unchanged.
- R11: A CSR write (`csr_we_i`) loads all three bits from `csr_wdata_i`, and `ie_o` shows them after one edge. An entry request in the same cycle wins over the write, and the write wins over a return.
- R12: A return through register 30 or 31 with `step_i` low, or by a register call, leaves `ie_o` unchanged.
- R13: The low two bits of `next_pc_o`, `link_data_o` and `fault_pc_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction retires this cycle |
| pc_i | input | 32 | Address of the retiring instruction |
| kind_i | input | 3 | Flow kind code |
| cmp_op_i | input | 3 | Compare code for branches |
| opa_i | input | 32 | First register operand / jump target |
| opb_i | input | 32 | Second register operand |
| opa_idx_i | input | 5 | Register number of `opa_i` |
| imm16_i | input | 16 | Branch word offset |
| imm26_i | input | 26 | Jump/call word offset |
| exc_entry_i | input | 1 | Exception entry request |
| brk_entry_i | input | 1 | Breakpoint entry request |
| csr_we_i | input | 1 | Enable register write |
| csr_wdata_i | input | 3 | Enable register write data |
| next_pc_o | output | 32 | Next instruction address |
| link_we_o | output | 1 | Return-link write strobe |
| link_idx_o | output | 5 | Return-link register number |
| link_data_o | output | 32 | Return-link value |
| sys_exc_o | output | 1 | System call raised |
| brk_exc_o | output | 1 | Break raised |
| fault_pc_o | output | 32 | Address of faulting instruction |
| ie_o | output | 3 | Interrupt-enable state |

## Verification
The PC and link outputs are combinational. A wrong target adder, a swapped compare sense or a bad sign extension shows on `next_pc_o` in the same cycle the instruction is presented. The enable state is the only storage. A bad save, restore or priority shows on `ie_o` one edge after the request. It then persists, so a nested exception-then-breakpoint sequence exposes it again when each return restores the global enable. Signed and unsigned compares are driven with operands whose sign bits differ, so that the two senses give different results.

// File: rtl/brie_pkg.sv
package brie_pkg;
  typedef enum logic [2:0] {
    K_SEQ, K_BCOND, K_BIMM, K_CALLI, K_JREG, K_CALLR, K_SCALL, K_BREAK
  } flow_kind_e;

  typedef enum logic [2:0] {
    C_EQ, C_NE, C_GT, C_GE, C_GTU, C_GEU, C_RSV6, C_RSV7
  } cmp_op_e;

  typedef struct packed {
    logic bie;
    logic eie;
    logic gie;
  } ie_t;
endpackage

// File: rtl/brie_cmp.sv
module brie_cmp #(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         take_o
);
  import brie_pkg::*;
  cmp_op_e op;
  assign op = cmp_op_e'(op_i);

  always_comb begin
    case (op)
      C_EQ:    take_o = (a_i == b_i);
      C_NE:    take_o = (a_i != b_i);
      C_GT:    take_o = ($signed(a_i) >  $signed(b_i));
      C_GE:    take_o = ($signed(a_i) >= $signed(b_i));
      C_GTU:   take_o = (a_i >  b_i);
      C_GEU:   take_o = (a_i >= b_i);
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brie_next_pc.sv
module brie_next_pc #(
  parameter int W     = 32,
  parameter int OFF16 = 16,
  parameter int OFF26 = 26
) (
  input  logic [2:0]       kind_i,
  input  logic [W-1:0]     pc_i,
  input  logic             take_i,
  input  logic [OFF16-1:0] imm16_i,
  input  logic [OFF26-1:0] imm26_i,
  input  logic [W-1:0]     reg_tgt_i,
  output logic [W-1:0]     next_pc_o,
  output logic [W-1:0]     seq_pc_o,
  output logic [W-1:0]     pc_al_o
);
  import brie_pkg::*;
  localparam int EXT16 = W - OFF16 - 2;
  localparam int EXT26 = W - OFF26 - 2;

  flow_kind_e   kind;
  logic [W-1:0] pc_al, seq_pc, br_off, jmp_off, raw;

  assign kind    = flow_kind_e'(kind_i);
  assign pc_al   = {pc_i[W-1:2], 2'b00};
  assign seq_pc  = pc_al + W'(4);
  assign br_off  = {{EXT16{imm16_i[OFF16-1]}}, imm16_i, 2'b00};
  assign jmp_off = {{EXT26{imm26_i[OFF26-1]}}, imm26_i, 2'b00};

  always_comb begin
    case (kind)
      K_SEQ:           raw = seq_pc;
      K_BCOND:         raw = take_i ? (pc_al + br_off) : seq_pc;
      K_BIMM, K_CALLI: raw = pc_al + jmp_off;
      K_JREG, K_CALLR: raw = reg_tgt_i;
      default:         raw = pc_al;
    endcase
  end

  assign next_pc_o = {raw[W-1:2], 2'b00};
  assign seq_pc_o  = seq_pc;
  assign pc_al_o   = pc_al;
endmodule

// File: rtl/brie_ie_reg.sv
module brie_ie_reg (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           exc_entry_i,
  input  logic           brk_entry_i,
  input  logic           csr_we_i,
  input  brie_pkg::ie_t  csr_data_i,
  input  logic           ret_exc_i,
  input  logic           ret_brk_i,
  output brie_pkg::ie_t  ie_o
);
  import brie_pkg::*;
  ie_t ie_q, ie_d;

  always_comb begin
    ie_d = ie_q;
    if (brk_entry_i) begin
      ie_d.bie = ie_q.gie;
      ie_d.gie = 1'b0;
    end else if (exc_entry_i) begin
      ie_d.eie = ie_q.gie;
      ie_d.gie = 1'b0;
    end else if (csr_we_i) begin
      ie_d = csr_data_i;
    end else if (ret_exc_i) begin
      ie_d.gie = ie_q.eie;
    end else if (ret_brk_i) begin
      ie_d.gie = ie_q.bie;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= '0;
    else         ie_q <= ie_d;
  end

  assign ie_o = ie_q;

  a_r9_exc_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i && !brk_entry_i |=> !ie_q.gie && ie_q.eie == $past(ie_q.gie)
                                    && ie_q.bie == $past(ie_q.bie));
  a_r9_brk_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_entry_i |=> !ie_q.gie && ie_q.bie == $past(ie_q.gie)
                    && ie_q.eie == $past(ie_q.eie));
  a_r10_exc_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_exc_i && !exc_entry_i && !brk_entry_i && !csr_we_i
      |=> ie_q.gie == $past(ie_q.eie) && $stable(ie_q.eie));
  a_r10_brk_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_brk_i && !exc_entry_i && !brk_entry_i && !csr_we_i
      |=> ie_q.gie == $past(ie_q.bie) && $stable(ie_q.bie));
  a_r11_csr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && !exc_entry_i && !brk_entry_i |=> ie_q == $past(csr_data_i));
endmodule

// File: rtl/brie_ctrl.sv
module brie_ctrl #(
  parameter int XLEN        = 32,
  parameter int REG_IDX_W   = 5,
  parameter int LINK_REG    = 29,
  parameter int EXC_RET_REG = 30,
  parameter int BRK_RET_REG = 31
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [2:0]           kind_i,
  input  logic [2:0]           cmp_op_i,
  input  logic [XLEN-1:0]      opa_i,
  input  logic [XLEN-1:0]      opb_i,
  input  logic [REG_IDX_W-1:0] opa_idx_i,
  input  logic [15:0]          imm16_i,
  input  logic [25:0]          imm26_i,
  input  logic                 exc_entry_i,
  input  logic                 brk_entry_i,
  input  logic                 csr_we_i,
  input  logic [2:0]           csr_wdata_i,
  output logic [XLEN-1:0]      next_pc_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]      link_data_o,
  output logic                 sys_exc_o,
  output logic                 brk_exc_o,
  output logic [XLEN-1:0]      fault_pc_o,
  output logic [2:0]           ie_o
);
  import brie_pkg::*;

  flow_kind_e    kind;
  logic          take;
  logic [XLEN-1:0] seq_pc, pc_al;
  logic          ret_exc, ret_brk, is_call;
  ie_t           ie_q;

  assign kind = flow_kind_e'(kind_i);

  brie_cmp #(.W(XLEN)) u_cmp (
    .op_i(cmp_op_i), .a_i(opa_i), .b_i(opb_i), .take_o(take)
  );

  brie_next_pc #(.W(XLEN)) u_npc (
    .kind_i(kind_i), .pc_i(pc_i), .take_i(take),
    .imm16_i(imm16_i), .imm26_i(imm26_i), .reg_tgt_i(opa_i),
    .next_pc_o(next_pc_o), .seq_pc_o(seq_pc), .pc_al_o(pc_al)
  );

  assign ret_exc = step_i && kind == K_JREG && opa_idx_i == REG_IDX_W'(EXC_RET_REG);
  assign ret_brk = step_i && kind == K_JREG && opa_idx_i == REG_IDX_W'(BRK_RET_REG);

  brie_ie_reg u_ie (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .exc_entry_i(exc_entry_i), .brk_entry_i(brk_entry_i),
    .csr_we_i(csr_we_i), .csr_data_i(ie_t'(csr_wdata_i)),
    .ret_exc_i(ret_exc), .ret_brk_i(ret_brk), .ie_o(ie_q)
  );

  assign is_call     = (kind == K_CALLI) || (kind == K_CALLR);
  assign link_we_o   = step_i && is_call;
  assign link_idx_o  = REG_IDX_W'(LINK_REG);
  assign link_data_o = seq_pc;
  assign sys_exc_o   = step_i && kind == K_SCALL;
  assign brk_exc_o   = step_i && kind == K_BREAK;
  assign fault_pc_o  = pc_al;
  assign ie_o        = ie_q;

  a_r13_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_pc_o[1:0] == 2'b00 && link_data_o[1:0] == 2'b00);
  a_r3_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == K_BCOND && !take |-> next_pc_o == link_data_o);
  a_r5_link_calls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> step_i && is_call);
  a_r7_exc_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sys_exc_o, brk_exc_o}));
  a_r7_hold_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_exc_o || brk_exc_o) |-> next_pc_o == fault_pc_o);
endmodule

// File: tb/brie_ctrl_tb.sv
module brie_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic [2:0]  kind_i = '0, cmp_op_i = '0, csr_wdata_i = '0;
  logic [4:0]  opa_idx_i = '0;
  logic [15:0] imm16_i = '0;
  logic [25:0] imm26_i = '0;
  logic        exc_entry_i = 1'b0, brk_entry_i = 1'b0, csr_we_i = 1'b0;
  logic [31:0] next_pc_o, link_data_o, fault_pc_o;
  logic        link_we_o, sys_exc_o, brk_exc_o;
  logic [4:0]  link_idx_o;
  logic [2:0]  ie_o;

  int n_chk = 0, n_bad = 0;
  logic [2:0] ie_m = 3'b000;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  brie_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_take(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) > $signed(b);
      3'd3: return $signed(a) >= $signed(b);
      3'd4: return a > b;
      3'd5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_next(input logic [2:0] k, input logic [31:0] pc,
      input bit tk, input logic [15:0] i16, input logic [25:0] i26, input logic [31:0] ra);
    logic [31:0] pa;
    pa = {pc[31:2], 2'b00};
    case (k)
      3'd0: return pa + 4;
      3'd1: return tk ? pa + {{14{i16[15]}}, i16, 2'b00} : pa + 4;
      3'd2, 3'd3: return pa + {{4{i26[25]}}, i26, 2'b00};
      3'd4, 3'd5: return {ra[31:2], 2'b00};
      default: return pa;
    endcase
  endfunction

  function automatic logic [2:0] m_ie(input logic [2:0] ie, input bit st, input logic [2:0] k,
      input logic [4:0] idx, input bit ex, input bit bk, input bit we, input logic [2:0] wd);
    logic [2:0] r;
    r = ie;
    if (bk) begin r[2] = ie[0]; r[0] = 1'b0; end
    else if (ex) begin r[1] = ie[0]; r[0] = 1'b0; end
    else if (we) r = wd;
    else if (st && k == 3'd4 && idx == 5'd30) r[0] = ie[1];
    else if (st && k == 3'd4 && idx == 5'd31) r[0] = ie[2];
    return r;
  endfunction

  // drive one cycle at negedge, check combinational outputs, predict ie
  task automatic cyc(input bit st, input logic [2:0] k, input logic [2:0] op,
      input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b, input logic [4:0] idx,
      input logic [15:0] i16, input logic [25:0] i26, input bit ex, input bit bk,
      input bit we, input logic [2:0] wd, input string tag);
    logic [31:0] en;
    logic [31:0] pa;
    @(negedge clk_i);
    chk(ie_o == ie_m, "R9/R10/R11/R12 ie state", {29'd0, ie_o}, {29'd0, ie_m});
    step_i = st; kind_i = k; cmp_op_i = op; pc_i = pc; opa_i = a; opb_i = b;
    opa_idx_i = idx; imm16_i = i16; imm26_i = i26; exc_entry_i = ex;
    brk_entry_i = bk; csr_we_i = we; csr_wdata_i = wd;
    #2;
    pa = {pc[31:2], 2'b00};
    en = m_next(k, pc, m_take(op, a, b), i16, i26, a);
    chk(next_pc_o == en, {tag, " R1/R2/R3/R4/R6 next_pc"}, next_pc_o, en);
    chk(next_pc_o[1:0] == 2'b00 && link_data_o[1:0] == 2'b00 && fault_pc_o[1:0] == 2'b00,
        "R13 alignment", {30'd0, next_pc_o[1:0]}, 32'd0);
    chk(link_we_o == (st && (k == 3'd3 || k == 3'd5)), "R5 link_we", {31'd0, link_we_o},
        {31'd0, st && (k == 3'd3 || k == 3'd5)});
    if (link_we_o)
      chk(link_data_o == pa + 4 && link_idx_o == 5'd29, "R5 link value", link_data_o, pa + 4);
    chk(sys_exc_o == (st && k == 3'd6) && brk_exc_o == (st && k == 3'd7), "R7 exc flags",
        {30'd0, sys_exc_o, brk_exc_o}, {30'd0, st && k == 3'd6, st && k == 3'd7});
    if (k >= 3'd6) chk(fault_pc_o == pa, "R7 fault_pc", fault_pc_o, pa);
    ie_m = m_ie(ie_m, st, k, idx, ex, bk, we, wd);
  endtask

  task automatic ie_only(input bit st, input logic [2:0] k, input logic [4:0] idx,
      input bit ex, input bit bk, input bit we, input logic [2:0] wd, input string tag);
    cyc(st, k, 3'd0, 32'h100, 32'h2000, 32'h0, idx, 16'h0, 26'h0, ex, bk, we, wd, tag);
  endtask

  task automatic expect_ie(input logic [2:0] e, input string tag);
    @(negedge clk_i);
    step_i = 0; exc_entry_i = 0; brk_entry_i = 0; csr_we_i = 0;
    chk(ie_o == e, tag, {29'd0, ie_o}, {29'd0, e});
    ie_m = ie_o == e ? e : ie_m;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ie_o == 3'b000, "R8 reset value", {29'd0, ie_o}, 32'd0);

    // directed branches: R2 R3 signed vs unsigned, negative offset
    cyc(1, 3'd1, 3'd2, 32'h1000, 32'hFFFF_FFFF, 32'h1, 5'd1, 16'hFFFC, 0, 0, 0, 0, 0, "R2 gt signed not taken");
    cyc(1, 3'd1, 3'd4, 32'h1000, 32'hFFFF_FFFF, 32'h1, 5'd1, 16'hFFFC, 0, 0, 0, 0, 0, "R3 gtu taken negative offset");
    cyc(1, 3'd1, 3'd0, 32'h1003, 32'h5, 32'h5, 5'd1, 16'h0010, 0, 0, 0, 0, 0, "R3 eq taken unaligned pc");
    cyc(1, 3'd1, 3'd6, 32'h1000, 32'h5, 32'h5, 5'd1, 16'h0010, 0, 0, 0, 0, 0, "R2 reserved code");
    cyc(1, 3'd2, 3'd0, 32'h8000, 0, 0, 5'd1, 0, 26'h3FF_FFFF, 0, 0, 0, 0, "R4 jump back one word");
    cyc(1, 3'd3, 3'd0, 32'h8000, 0, 0, 5'd1, 0, 26'h200_0000, 0, 0, 0, 0, "R4 calli most negative");
    cyc(1, 3'd5, 3'd0, 32'h40, 32'h1237, 0, 5'd7, 0, 0, 0, 0, 0, 0, "R6 callr aligned target");
    cyc(1, 3'd6, 3'd0, 32'h44, 0, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R7 scall");
    cyc(1, 3'd7, 3'd0, 32'h48, 0, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R7 break");

    // nested enable save/restore: R9 R10 R11
    ie_only(0, 3'd0, 5'd0, 0, 0, 1, 3'b001, "R11 set gie");
    ie_only(0, 3'd0, 5'd0, 1, 0, 0, 3'b000, "R9 exc entry");
    expect_ie(3'b010, "R9 exc saved gie");
    ie_only(0, 3'd0, 5'd0, 0, 0, 1, 3'b011, "R11 reenable in handler");
    ie_only(0, 3'd0, 5'd0, 0, 1, 0, 3'b000, "R9 brk entry");
    expect_ie(3'b110, "R9 brk saved gie");
    ie_only(0, 3'd4, 5'd31, 0, 0, 0, 0, "R12 return without step");
    expect_ie(3'b110, "R12 no step no change");
    ie_only(1, 3'd5, 5'd31, 0, 0, 0, 0, "R12 callr through 31");
    expect_ie(3'b110, "R12 call does not restore");
    ie_only(1, 3'd4, 5'd31, 0, 0, 0, 0, "R10 brk return");
    expect_ie(3'b111, "R10 brk restored");
    ie_only(0, 3'd0, 5'd0, 0, 0, 1, 3'b010, "R11 clear gie");
    ie_only(1, 3'd4, 5'd30, 0, 0, 0, 0, "R10 exc return");
    expect_ie(3'b011, "R10 exc restored");
    ie_only(1, 3'd4, 5'd30, 1, 1, 1, 3'b101, "R9 priority all");
    expect_ie(3'b110, "R9 brk wins");
    ie_only(1, 3'd4, 5'd31, 0, 0, 1, 3'b001, "R11 csr over return");
    expect_ie(3'b001, "R11 csr wins");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [4:0] idx;
      a = $urandom;
      b = ($urandom % 4 == 0) ? a : $urandom;
      idx = ($urandom % 2 == 0) ? 5'(29 + $urandom % 3) : 5'($urandom);
      cyc($urandom % 4 != 0, 3'($urandom), 3'($urandom), $urandom, a, b, idx,
          16'($urandom), 26'($urandom), $urandom % 8 == 0, $urandom % 8 == 0,
          $urandom % 6 == 0, 3'($urandom), "rand");
    end
    @(negedge clk_i);
    chk(ie_o == ie_m, "R9/R10/R11 final ie", {29'd0, ie_o}, {29'd0, ie_m});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule